// File: doc/BRIEF.md
# Input Capture Timer Channel

A free-running 16-bit counter that timestamps transitions on a measurement pin. Each qualifying transition copies the current count into one of two capture registers. The loads alternate: a first register, then a second one. The edge polarity for each register is chosen on its own, so a pulse width or a period can be measured directly from the two values.

An external trigger restarts the count from zero. It comes from the measurement pin or from an auxiliary pin, on a selectable edge. A match against a compare value can also restart the count. After the second capture the counter can halt, or the channel clock can be switched off.

Sticky status flags record the block's events. A mask is built from write-only set and clear strobes, and a single interrupt line is raised whenever a flagged event is unmasked. The count-enable tick and both pins arrive already synchronised to `clk`.

Top module: `cap_timer_chan`

## Requirements
- R1: `cfg_lda` selects the `pin_a` edge that loads `cap_a` (0 none, 1 rising, 2 falling, 3 both). The loaded value is the count held just before that clock edge.
- R2: `cfg_ldb` selects the `pin_a` edge that loads `cap_b`, using the R1 encoding. `cap_b` loads only after a load of `cap_a`. `cap_a` loads again only once `cap_b` has loaded. The two never load in the same cycle.
- R3: `cfg_trg_edge` (R1 encoding) selects the trigger edge. The trigger comes from `pin_a` when `cfg_trg_from_a` is 1 and from `pin_b` otherwise. A trigger forces the count to 0, releases a halt and sets status bit 7.
- R4: While counting, a count equal to `cmp_c` sets status bit 4. If `cfg_cmp_rst` is 1, the next count is 0 instead of `cmp_c`+1.
- R5: With `cfg_stop_b` set, a `cap_b` load freezes the count at the captured value until a trigger.
- R6: With `cfg_dis_b` set, a `cap_b` load clears `clk_active` and freezes the count. A `clk_on` pulse resumes counting. `clk_off` clears `clk_active` and wins over `clk_on`.
- R7: A counting step from the all-ones value wraps to 0 and sets status bit 0.
- R8: A load into a capture register whose previous value has not been read sets status bit 1. Pulsing `rd_a` or `rd_b` marks that register as read.
- R9: Status bits 5 and 6 flag `cap_a` and `cap_b` loads, and bits 2 and 3 are always 0. Status bits are sticky and are cleared by `rd_stat`; an event in the same cycle as `rd_stat` stays set.
- R10: `ier_wr` sets the `mask` bits that are 1 in `ier_data`, and `idr_wr` clears the bits that are 1 in `idr_data`. A bit set and cleared in the same cycle ends up cleared.
- R11: `irq` is 1 exactly when some status bit and the matching mask bit are both 1.
- R12: After reset the count, both capture registers, status and mask are 0 and `clk_active` is 0. No counting happens until `clk_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Count enable from the prescaler |
| pin_a | input | 1 | Measurement pin, synchronised |
| pin_b | input | 1 | Auxiliary trigger pin, synchronised |
| clk_on | input | 1 | Pulse: enable channel clock |
| clk_off | input | 1 | Pulse: disable channel clock |
| cfg_lda | input | 2 | Edge that loads cap_a |
| cfg_ldb | input | 2 | Edge that loads cap_b |
| cfg_trg_edge | input | 2 | Trigger edge |
| cfg_trg_from_a | input | 1 | 1: trigger from pin_a, 0: from pin_b |
| cfg_cmp_rst | input | 1 | Restart count on compare match |
| cfg_stop_b | input | 1 | Halt count after cap_b load |
| cfg_dis_b | input | 1 | Disable clock after cap_b load |
| cmp_c | input | 16 | Compare value |
| rd_a | input | 1 | Pulse: cap_a has been read |
| rd_b | input | 1 | Pulse: cap_b has been read |
| rd_stat | input | 1 | Pulse: clear sticky status |
| ier_wr | input | 1 | Mask set strobe |
| ier_data | input | 8 | Mask bits to set |
| idr_wr | input | 1 | Mask clear strobe |
| idr_data | input | 8 | Mask bits to clear |
| cnt_val | output | 16 | Current count |
| clk_active | output | 1 | Channel clock enabled |
| cap_a | output | 16 | First capture register |
| cap_b | output | 16 | Second capture register |
| status | output | 8 | Sticky status flags |
| mask | output | 8 | Interrupt mask |
| irq | output | 1 | Interrupt request |

## Verification
If the alternation flag goes wrong, the wrong capture register moves on the very next qualifying `pin_a` edge. The error is visible on `cap_a` or `cap_b` one cycle after that edge. A lost unread flag shows up as a missing or spurious status bit 1 on the next load. A faulty halt or disable state shows on `cnt_val` within one cycle, because the count either moves when it should hold or holds when it should move. Mask and status faults reach `irq` in the same cycle, since the line has no register of its own.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [1:0] {
    EDG_OFF  = 2'd0,
    EDG_RISE = 2'd1,
    EDG_FALL = 2'd2,
    EDG_ANY  = 2'd3
  } edge_mode_e;

  localparam int unsigned NSTAT   = 8;
  localparam int unsigned SB_OVF  = 0;
  localparam int unsigned SB_LOVR = 1;
  localparam int unsigned SB_CMPC = 4;
  localparam int unsigned SB_LDA  = 5;
  localparam int unsigned SB_LDB  = 6;
  localparam int unsigned SB_TRG  = 7;

  // Edge qualifier shared by both capture selectors and the trigger selector.
  function automatic logic edge_hit(input logic [1:0] mode, input logic rise, input logic fall);
    case (edge_mode_e'(mode))
      EDG_RISE: return rise;
      EDG_FALL: return fall;
      EDG_ANY:  return rise | fall;
      default:  return 1'b0;
    endcase
  endfunction

  // Sticky flags: a new event survives a same-cycle clear.
  function automatic logic [NSTAT-1:0] stat_next(input logic [NSTAT-1:0] cur,
                                                 input logic clr,
                                                 input logic [NSTAT-1:0] ev);
    return (clr ? '0 : cur) | ev;
  endfunction

  // Mask update: clear wins over set.
  function automatic logic [NSTAT-1:0] mask_next(input logic [NSTAT-1:0] cur,
                                                 input logic [NSTAT-1:0] set,
                                                 input logic [NSTAT-1:0] clr);
    return (cur | set) & ~clr;
  endfunction

endpackage

// File: rtl/cap_edge_det.sv
module cap_edge_det #(
  parameter int NPIN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin,
  output logic [NPIN-1:0] rise,
  output logic [NPIN-1:0] fall
);
  logic [NPIN-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin;
  end

  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
      assign rise[i] =  pin[i] & ~prev_q[i];
      assign fall[i] = ~pin[i] &  prev_q[i];
    end
  endgenerate
endmodule

// File: rtl/cap_counter.sv
module cap_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_tick,
  input  logic         clk_on,
  input  logic         clk_off,
  input  logic         trg_ev,
  input  logic         ld_b_ev,
  input  logic         cfg_stop_b,
  input  logic         cfg_dis_b,
  input  logic         cfg_cmp_rst,
  input  logic [W-1:0] cmp_val,
  output logic [W-1:0] cnt_q,
  output logic         clk_active,
  output logic         cmp_ev,
  output logic         ovf_ev
);
  localparam logic [W-1:0] CNT_MAX = '1;
  localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

  logic stopped_q;
  logic halt_now;
  logic adv_ev;
  logic cmp_rst_ev;

  function automatic logic [W-1:0] count_next(input logic [W-1:0] cur,
                                               input logic zero,
                                               input logic step);
    if (zero) return '0;
    if (step) return cur + CNT_ONE;
    return cur;
  endfunction

  assign halt_now   = ld_b_ev & (cfg_stop_b | cfg_dis_b);
  assign adv_ev     = clk_active & ~stopped_q & cnt_tick & ~halt_now;
  assign cmp_ev     = adv_ev & (cnt_q == cmp_val);
  assign cmp_rst_ev = cmp_ev & cfg_cmp_rst;
  assign ovf_ev     = adv_ev & (cnt_q == CNT_MAX) & ~cmp_rst_ev & ~trg_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      stopped_q  <= 1'b0;
      clk_active <= 1'b0;
    end else begin
      cnt_q <= count_next(cnt_q, trg_ev | cmp_rst_ev, adv_ev);
      if (trg_ev)                       stopped_q <= 1'b0;
      else if (ld_b_ev && cfg_stop_b)   stopped_q <= 1'b1;
      if (clk_off || (ld_b_ev && cfg_dis_b)) clk_active <= 1'b0;
      else if (clk_on)                       clk_active <= 1'b1;
    end
  end
endmodule

// File: rtl/cap_regs.sv
module cap_regs
  import cap_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_a,
  input  logic             fall_a,
  input  logic [1:0]       cfg_lda,
  input  logic [1:0]       cfg_ldb,
  input  logic [W-1:0]     cnt_q,
  input  logic             trg_ev,
  input  logic             cmp_ev,
  input  logic             ovf_ev,
  input  logic             rd_a,
  input  logic             rd_b,
  input  logic             rd_stat,
  input  logic             ier_wr,
  input  logic [NSTAT-1:0] ier_data,
  input  logic             idr_wr,
  input  logic [NSTAT-1:0] idr_data,
  output logic [W-1:0]     cap_a,
  output logic [W-1:0]     cap_b,
  output logic [NSTAT-1:0] status,
  output logic [NSTAT-1:0] mask,
  output logic             irq,
  output logic             ld_a_ev,
  output logic             ld_b_ev
);
  logic             wait_b_q;
  logic             a_full_q;
  logic             b_full_q;
  logic             ovr_ev;
  logic [NSTAT-1:0] ev;

  assign ld_a_ev = edge_hit(cfg_lda, rise_a, fall_a) & ~wait_b_q;
  assign ld_b_ev = edge_hit(cfg_ldb, rise_a, fall_a) &  wait_b_q;
  assign ovr_ev  = (ld_a_ev & a_full_q) | (ld_b_ev & b_full_q);

  always_comb begin
    ev          = '0;
    ev[SB_OVF]  = ovf_ev;
    ev[SB_LOVR] = ovr_ev;
    ev[SB_CMPC] = cmp_ev;
    ev[SB_LDA]  = ld_a_ev;
    ev[SB_LDB]  = ld_b_ev;
    ev[SB_TRG]  = trg_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a    <= '0;
      cap_b    <= '0;
      wait_b_q <= 1'b0;
      a_full_q <= 1'b0;
      b_full_q <= 1'b0;
      status   <= '0;
      mask     <= '0;
    end else begin
      if (ld_a_ev) begin
        cap_a    <= cnt_q;
        wait_b_q <= 1'b1;
      end else if (ld_b_ev) begin
        cap_b    <= cnt_q;
        wait_b_q <= 1'b0;
      end
      if (ld_a_ev)   a_full_q <= 1'b1;
      else if (rd_a) a_full_q <= 1'b0;
      if (ld_b_ev)   b_full_q <= 1'b1;
      else if (rd_b) b_full_q <= 1'b0;
      status <= stat_next(status, rd_stat, ev);
      mask   <= mask_next(mask, ier_wr ? ier_data : '0, idr_wr ? idr_data : '0);
    end
  end

  assign irq = |(status & mask);
endmodule

// File: rtl/cap_timer_chan.sv
module cap_timer_chan
  import cap_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_tick,
  input  logic         pin_a,
  input  logic         pin_b,
  input  logic         clk_on,
  input  logic         clk_off,
  input  logic [1:0]   cfg_lda,
  input  logic [1:0]   cfg_ldb,
  input  logic [1:0]   cfg_trg_edge,
  input  logic         cfg_trg_from_a,
  input  logic         cfg_cmp_rst,
  input  logic         cfg_stop_b,
  input  logic         cfg_dis_b,
  input  logic [W-1:0] cmp_c,
  input  logic         rd_a,
  input  logic         rd_b,
  input  logic         rd_stat,
  input  logic         ier_wr,
  input  logic [7:0]   ier_data,
  input  logic         idr_wr,
  input  logic [7:0]   idr_data,
  output logic [W-1:0] cnt_val,
  output logic         clk_active,
  output logic [W-1:0] cap_a,
  output logic [W-1:0] cap_b,
  output logic [7:0]   status,
  output logic [7:0]   mask,
  output logic         irq
);
  localparam int NPIN = 2;

  logic [NPIN-1:0] rise;
  logic [NPIN-1:0] fall;
  logic            trg_ev;
  logic            ld_a_ev;
  logic            ld_b_ev;
  logic            cmp_ev;
  logic            ovf_ev;

  cap_edge_det #(.NPIN(NPIN)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  ({pin_b, pin_a}),
    .rise (rise),
    .fall (fall)
  );

  assign trg_ev = edge_hit(cfg_trg_edge,
                           cfg_trg_from_a ? rise[0] : rise[1],
                           cfg_trg_from_a ? fall[0] : fall[1]);

  cap_counter #(.W(W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_tick   (cnt_tick),
    .clk_on     (clk_on),
    .clk_off    (clk_off),
    .trg_ev     (trg_ev),
    .ld_b_ev    (ld_b_ev),
    .cfg_stop_b (cfg_stop_b),
    .cfg_dis_b  (cfg_dis_b),
    .cfg_cmp_rst(cfg_cmp_rst),
    .cmp_val    (cmp_c),
    .cnt_q      (cnt_val),
    .clk_active (clk_active),
    .cmp_ev     (cmp_ev),
    .ovf_ev     (ovf_ev)
  );

  cap_regs #(.W(W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise_a  (rise[0]),
    .fall_a  (fall[0]),
    .cfg_lda (cfg_lda),
    .cfg_ldb (cfg_ldb),
    .cnt_q   (cnt_val),
    .trg_ev  (trg_ev),
    .cmp_ev  (cmp_ev),
    .ovf_ev  (ovf_ev),
    .rd_a    (rd_a),
    .rd_b    (rd_b),
    .rd_stat (rd_stat),
    .ier_wr  (ier_wr),
    .ier_data(ier_data),
    .idr_wr  (idr_wr),
    .idr_data(idr_data),
    .cap_a   (cap_a),
    .cap_b   (cap_b),
    .status  (status),
    .mask    (mask),
    .irq     (irq),
    .ld_a_ev (ld_a_ev),
    .ld_b_ev (ld_b_ev)
  );
endmodule

// File: rtl/cap_timer_chan_chk.sv
module cap_timer_chan_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ld_a_ev,
  input logic         ld_b_ev,
  input logic         trg_ev,
  input logic         ovf_ev,
  input logic         cfg_stop_b,
  input logic         cfg_dis_b,
  input logic [W-1:0] cnt_val,
  input logic [W-1:0] cap_a,
  input logic         clk_active,
  input logic [7:0]   status,
  input logic [7:0]   mask,
  input logic         irq,
  input logic         ier_wr,
  input logic [7:0]   ier_data,
  input logic         idr_wr
);
  a_r1_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
    ld_a_ev |=> (cap_a == $past(cnt_val)));

  a_r2_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_a_ev && ld_b_ev));

  a_r3_trigger_zero: assert property (@(posedge clk) disable iff (!rst_n)
    trg_ev |=> (cnt_val == '0 && status[7]));

  a_r5_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_b_ev && cfg_stop_b && !trg_ev) |=> $stable(cnt_val));

  a_r6_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_b_ev && cfg_dis_b) |=> !clk_active);

  a_r7_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> (status[0] && cnt_val == '0));

  a_r10_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_wr && !idr_wr) |=> ((mask & $past(ier_data)) == $past(ier_data)));

  a_r11_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 8'h00) |-> !irq);
endmodule

bind cap_timer_chan cap_timer_chan_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_a_ev   (ld_a_ev),
  .ld_b_ev   (ld_b_ev),
  .trg_ev    (trg_ev),
  .ovf_ev    (ovf_ev),
  .cfg_stop_b(cfg_stop_b),
  .cfg_dis_b (cfg_dis_b),
  .cnt_val   (cnt_val),
  .cap_a     (cap_a),
  .clk_active(clk_active),
  .status    (status),
  .mask      (mask),
  .irq       (irq),
  .ier_wr    (ier_wr),
  .ier_data  (ier_data),
  .idr_wr    (idr_wr)
);

// File: tb/cap_timer_chan_bench.sv
`timescale 1ns/1ps
module cap_timer_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_tick, pin_a, pin_b, clk_on, clk_off;
  logic [1:0]  cfg_lda, cfg_ldb, cfg_trg_edge;
  logic        cfg_trg_from_a, cfg_cmp_rst, cfg_stop_b, cfg_dis_b;
  logic [15:0] cmp_c;
  logic        rd_a, rd_b, rd_stat, ier_wr, idr_wr;
  logic [7:0]  ier_data, idr_data;
  logic [15:0] cnt_val, cap_a, cap_b;
  logic        clk_active, irq;
  logic [7:0]  status, mask;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  cap_timer_chan u_cap_timer_chan (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .pin_a(pin_a), .pin_b(pin_b),
    .clk_on(clk_on), .clk_off(clk_off), .cfg_lda(cfg_lda), .cfg_ldb(cfg_ldb),
    .cfg_trg_edge(cfg_trg_edge), .cfg_trg_from_a(cfg_trg_from_a),
    .cfg_cmp_rst(cfg_cmp_rst), .cfg_stop_b(cfg_stop_b), .cfg_dis_b(cfg_dis_b),
    .cmp_c(cmp_c), .rd_a(rd_a), .rd_b(rd_b), .rd_stat(rd_stat),
    .ier_wr(ier_wr), .ier_data(ier_data), .idr_wr(idr_wr), .idr_data(idr_data),
    .cnt_val(cnt_val), .clk_active(clk_active), .cap_a(cap_a), .cap_b(cap_b),
    .status(status), .mask(mask), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cnt_tick = 1'b0; pin_a = 1'b0; pin_b = 1'b0;
    clk_on = 1'b0; clk_off = 1'b0; cfg_lda = 2'd0; cfg_ldb = 2'd0;
    cfg_trg_edge = 2'd0; cfg_trg_from_a = 1'b0; cfg_cmp_rst = 1'b0;
    cfg_stop_b = 1'b0; cfg_dis_b = 1'b0; cmp_c = 16'd500;
    rd_a = 1'b0; rd_b = 1'b0; rd_stat = 1'b0;
    ier_wr = 1'b0; idr_wr = 1'b0; ier_data = 8'h00; idr_data = 8'h00;
    tick(3);
    rst_n = 1'b1;
    cnt_tick = 1'b1;
    tick(1);
  endtask

  task automatic start_clock();
    clk_on = 1'b1; tick(1); clk_on = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R12 count", cnt_val, 0);
    chk("R12 status", status, 0);
    chk("R12 mask", mask, 0);
    chk("R12 irq", irq, 0);
    chk("R12 clk_active", clk_active, 0);
    chk("R12 cap_a", cap_a, 0);
    chk("R12 cap_b", cap_b, 0);
    tick(3);
    chk("R12 no count before clk_on", cnt_val, 0);
  endtask

  task automatic t_capture_order();
    logic [15:0] v1, v2, v3, v4, v5;
    do_reset(); start_clock();
    cfg_lda = 2'd1; cfg_ldb = 2'd2;
    tick(3);
    v1 = cnt_val; pin_a = 1'b1; tick(1);
    chk("R1 rising loads cap_a", cap_a, v1);
    chk("R9 A-loaded flag", status[5], 1);
    tick(2);
    v2 = cnt_val; pin_a = 1'b0; tick(1);
    chk("R2 falling loads cap_b", cap_b, v2);
    chk("R9 B-loaded flag", status[6], 1);
    chk("R9 bits 2,3 zero", status[3:2], 0);
    cfg_lda = 2'd0; pin_a = 1'b1; tick(1);
    chk("R1 mode none ignores edge", cap_a, v1);
    pin_a = 1'b0; tick(1);
    chk("R2 cap_b waits for cap_a", cap_b, v2);
    cfg_lda = 2'd3; cfg_ldb = 2'd3; tick(1);
    v3 = cnt_val; pin_a = 1'b1; tick(1);
    chk("R1 both-edge mode loads cap_a", cap_a, v3);
    v4 = cnt_val; pin_a = 1'b0; tick(1);
    chk("R2 alternation to cap_b", cap_b, v4);
    v5 = cnt_val; pin_a = 1'b1; tick(1);
    chk("R2 alternation back to cap_a", cap_a, v5);
    chk("R2 cap_b unchanged", cap_b, v4);
  endtask

  task automatic t_overrun();
    logic [15:0] v;
    do_reset(); start_clock();
    cfg_lda = 2'd1; cfg_ldb = 2'd2;
    pin_a = 1'b1; tick(1);
    pin_a = 1'b0; tick(1);
    chk("R8 no overrun on first pair", status[1], 0);
    pin_a = 1'b1; tick(1);
    chk("R8 overrun on unread cap_a", status[1], 1);
    rd_a = 1'b1; rd_b = 1'b1; rd_stat = 1'b1; tick(1);
    rd_a = 1'b0; rd_b = 1'b0; rd_stat = 1'b0;
    chk("R9 status cleared by read", status, 8'h00);
    pin_a = 1'b0; rd_stat = 1'b1; tick(1);
    rd_stat = 1'b0;
    chk("R9 event beats clear, R8 no overrun after read", status, 8'h40);
    v = cnt_val; pin_a = 1'b1; tick(1);
    chk("R8 no overrun after cap_a read", status[1], 0);
    chk("R1 cap_a reload value", cap_a, v);
  endtask

  task automatic t_trigger();
    logic [15:0] v;
    do_reset(); start_clock();
    cfg_trg_edge = 2'd1; cfg_trg_from_a = 1'b0;
    tick(4);
    pin_b = 1'b1; tick(1);
    chk("R3 pin_b rising restarts count", cnt_val, 0);
    chk("R3 trigger flag", status[7], 1);
    pin_b = 1'b0; tick(3);
    chk("R3 falling ignored in rising mode", cnt_val, 3);
    cfg_trg_from_a = 1'b1; v = cnt_val; pin_b = 1'b1; tick(1);
    chk("R3 pin_b ignored when pin_a selected", cnt_val, v + 16'd1);
    pin_a = 1'b1; tick(1);
    chk("R3 pin_a rising restarts count", cnt_val, 0);
    cfg_trg_edge = 2'd0; tick(2); pin_a = 1'b0; tick(1); pin_a = 1'b1; tick(1);
    chk("R3 mode none never triggers", cnt_val, 4);
    cfg_trg_edge = 2'd2; cfg_trg_from_a = 1'b0; pin_b = 1'b0; tick(1);
    chk("R3 pin_b falling restarts count", cnt_val, 0);
  endtask

  task automatic t_compare();
    do_reset(); start_clock();
    cfg_trg_edge = 2'd1; cfg_trg_from_a = 1'b1; cmp_c = 16'd10; cfg_cmp_rst = 1'b1;
    pin_a = 1'b1; tick(1);
    pin_a = 1'b0;
    chk("R4 start from trigger", cnt_val, 0);
    tick(10);
    chk("R4 reaches compare value", cnt_val, 10);
    chk("R4 flag not yet set", status[4], 0);
    tick(1);
    chk("R4 compare restart", cnt_val, 0);
    chk("R4 compare flag", status[4], 1);
    cfg_cmp_rst = 1'b0; rd_stat = 1'b1; tick(1);
    rd_stat = 1'b0; pin_a = 1'b1; tick(1);
    pin_a = 1'b0;
    tick(11);
    chk("R4 no restart when disabled", cnt_val, 11);
    chk("R4 flag without restart", status[4], 1);
  endtask

  task automatic t_stop();
    logic [15:0] v;
    do_reset(); start_clock();
    cfg_stop_b = 1'b1; cfg_lda = 2'd1; cfg_ldb = 2'd2; cfg_trg_edge = 2'd1;
    tick(2); pin_a = 1'b1; tick(2);
    v = cnt_val; pin_a = 1'b0; tick(1);
    chk("R2 cap_b value", cap_b, v);
    chk("R5 count frozen at capture", cnt_val, v);
    tick(4);
    chk("R5 count stays frozen", cnt_val, v);
    chk("R5 clock still active", clk_active, 1);
    pin_b = 1'b1; tick(1);
    chk("R5 trigger releases halt", cnt_val, 0);
    tick(3);
    chk("R5 counting resumed", cnt_val, 3);
  endtask

  task automatic t_disable();
    logic [15:0] v;
    do_reset(); start_clock();
    cfg_dis_b = 1'b1; cfg_lda = 2'd1; cfg_ldb = 2'd2;
    tick(2); pin_a = 1'b1; tick(2);
    v = cnt_val; pin_a = 1'b0; tick(1);
    chk("R6 clock disabled after cap_b", clk_active, 0);
    tick(4);
    chk("R6 count held while disabled", cnt_val, v);
    start_clock();
    chk("R6 clk_on re-enables", clk_active, 1);
    chk("R6 no step on enable cycle", cnt_val, v);
    tick(2);
    chk("R6 counting after re-enable", cnt_val, v + 16'd2);
    clk_on = 1'b1; clk_off = 1'b1; tick(1);
    clk_on = 1'b0; clk_off = 1'b0;
    chk("R6 clk_off wins over clk_on", clk_active, 0);
  endtask

  task automatic t_overflow();
    do_reset(); start_clock();
    cfg_trg_edge = 2'd1; cfg_trg_from_a = 1'b1; cmp_c = 16'd100;
    pin_a = 1'b1; tick(1); pin_a = 1'b0;
    tick(65535);
    chk("R7 at all-ones", cnt_val, 16'hFFFF);
    chk("R7 no overflow yet", status[0], 0);
    tick(1);
    chk("R7 wrap to zero", cnt_val, 0);
    chk("R7 overflow flag", status[0], 1);
  endtask

  task automatic t_mask();
    do_reset();
    cfg_trg_edge = 2'd1; cfg_trg_from_a = 1'b1;
    pin_a = 1'b1; tick(1);
    chk("R3 trigger flag only", status, 8'h80);
    chk("R11 masked event no irq", irq, 0);
    ier_wr = 1'b1; ier_data = 8'h80; tick(1);
    ier_data = 8'h01; tick(1); ier_wr = 1'b0;
    chk("R10 mask set", mask, 8'h81);
    chk("R11 unmasked event raises irq", irq, 1);
    idr_wr = 1'b1; idr_data = 8'h80; tick(1); idr_wr = 1'b0;
    chk("R10 mask clear", mask, 8'h01);
    chk("R11 irq drops when masked", irq, 0);
    ier_wr = 1'b1; ier_data = 8'h02; idr_wr = 1'b1; idr_data = 8'h02; tick(1);
    ier_wr = 1'b0; idr_wr = 1'b0;
    chk("R10 clear wins over set", mask, 8'h01);
    ier_wr = 1'b1; ier_data = 8'h80; rd_stat = 1'b1; tick(1);
    ier_wr = 1'b0; rd_stat = 1'b0;
    chk("R9 status cleared", status, 8'h00);
    chk("R11 no irq without status", irq, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_capture_order();
    t_overrun();
    t_trigger();
    t_compare();
    t_stop();
    t_disable();
    t_mask();
    t_overflow();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule